// File: doc/BRIEF.md
# Display Clock Frequency Change Sequencer

This block carries out a complete change of the display-core clock. A caller gives a target frequency in kHz together with a one-cycle start strobe. The block decodes the target into a PLL multiplier and a post-divider code. It tells the power controller through a mailbox that a change is coming. When the change calls for it, the block turns the display PLL off and on again. It then rewrites the clock control image. Last, it reports the new frequency to the power controller. The sequence ends with one `done` pulse, and `err` and `err_code` tell the caller whether it worked and why not if it failed.

The output frequency is 19.2 MHz × ratio / 2 / divider. The 19200 kHz target is the bypass setting: the PLL is left off and the control image is not written. Every wait on the PLL lock status has a time limit in cycles. The limit comes from the parameters for the clock period and for the wait time.

Top module: `dclk_seq`

## Requirements
- R1: Only the targets 19200, 144000, 288000, 384000, 576000 and 624000 kHz are accepted. Any other value ends the request with `err_code` 1 and touches neither the mailbox, the PLL nor the control image.
- R2: `pll_ratio` gets 60 for 144000, 288000, 384000 and 576000 kHz, and 65 for 624000 kHz. The divider code in `ctl_img[23:22]` is 3 (÷4), 2 (÷2), 1 (÷1.5) and 0 (÷1) for 144000, 288000, 384000 and 576000 kHz, and 0 for 624000 kHz.
- R3: Each accepted request first raises `mbx_req` with `mbx_cmd` 0x17 and `mbx_data` 0x80000000. If the mailbox answers with `mbx_fail`, the request ends with `err_code` 2 and the PLL and the control image are left unchanged.
- R4: `pll_en` is cleared, and the block waits for `pll_lock` to go low, only in three cases: the target is 19200 kHz, the target is 624000 kHz, or the frequency recovered from the control image is 624000 kHz.
- R5: Each lock or unlock wait is limited to LOCK_WAIT_NS×1000/CLK_PERIOD_PS cycles, rounded up. If the unlock wait runs out, the request ends with `err_code` 3. If the lock wait runs out, it ends with `err_code` 4. Either timeout also skips the final mailbox message.
- R6: For a target other than bypass, the block writes `pll_ratio` first. `pll_en` then rises, and only after `pll_en` and `pll_lock` are both high is `ctl_img` written.
- R7: `ctl_img[16]` is 1 when the written target is 500000 kHz or more, and 0 otherwise.
- R8: `ctl_img[10:0]` gets (kHz−1000)/500, truncated. The other fields keep their bits through a read-modify-write. A bypass request leaves `ctl_img` unchanged. The reset value is 0x00000024.
- R9: After the change, the block sends a mailbox message with command 0x17 and data ceil(kHz/25000). `cur_khz` takes the target only if that message succeeds. If it fails, the request ends with `err_code` 5.
- R10: `done` is a one-cycle pulse that ends every accepted request. `err` is high only together with `done` and only on failure. `busy` is high from the cycle after the strobe until `done`, and a strobe seen while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `pll_en`, `mbx_req` and `pll_ratio` are 0, `err_code` is 0, `cur_khz` is 19200 and `ctl_img` is 0x00000024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start strobe for a change |
| req_khz | input | 20 | Target frequency in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Failure flag, valid with done |
| err_code | output | 3 | Failure cause of the last request |
| cur_khz | output | 20 | Frequency last confirmed by the mailbox |
| mbx_req | output | 1 | Mailbox request, held until ack |
| mbx_cmd | output | 8 | Mailbox command |
| mbx_data | output | 32 | Mailbox payload |
| mbx_ack | input | 1 | Mailbox completion pulse |
| mbx_fail | input | 1 | Mailbox failure, valid with ack |
| pll_en | output | 1 | PLL enable |
| pll_lock | input | 1 | PLL lock status |
| pll_ratio | output | 8 | PLL ratio field image |
| ctl_img | output | 32 | Clock control register image |

## Verification
The hardest paths to reach are the two lock timeouts and the PLL-toggle decision. The toggle decision depends on what an earlier request left in the control image, and not on the request being made now. The bench chains its requests so that a 624000 kHz request is followed by a lower target, and so that a failed final message leaves `cur_khz` out of step with the image. Its PLL model can be switched to never lock or to stay locked, so that each timeout fires while the enable is in the right state. A second start strobe is pulsed in the middle of a sequence to show that the block ignores it.

// File: rtl/dclk_pkg.sv
`timescale 1ns/1ps
package dclk_pkg;
    localparam int KHZ_W   = 20;
    localparam int FIELD_W = 11;
    localparam int RATIO_W = 8;
    localparam int CTL_W   = 32;
    localparam int DIV_LSB = 22;
    localparam int PRE_BIT = 16;

    localparam logic [7:0]       MBX_CMD_FREQ    = 8'h17;
    localparam logic [31:0]      MBX_NOTIFY_DATA = 32'h8000_0000;
    localparam logic [KHZ_W-1:0] KHZ_BYPASS      = 20'd19200;
    localparam logic [KHZ_W-1:0] KHZ_TOP         = 20'd624000;
    localparam logic [KHZ_W-1:0] KHZ_PRECHARGE   = 20'd500000;
    localparam logic [RATIO_W-1:0] RATIO_BASE    = 8'd60;
    localparam logic [RATIO_W-1:0] RATIO_HIGH    = 8'd65;

    typedef enum logic [1:0] {
        DIV_1   = 2'd0,
        DIV_1P5 = 2'd1,
        DIV_2   = 2'd2,
        DIV_4   = 2'd3
    } div_sel_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_BAD_FREQ  = 3'd1,
        ERR_NOTIFY    = 3'd2,
        ERR_UNLOCK_TO = 3'd3,
        ERR_LOCK_TO   = 3'd4,
        ERR_FINAL     = 3'd5
    } err_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NOTIFY,
        ST_PLL_OFF,
        ST_RATIO,
        ST_PLL_ON,
        ST_CTL,
        ST_FINAL,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic               valid;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
        div_sel_e           div;
        logic               precharge;
        logic [FIELD_W-1:0] field;
        logic [31:0]        final_data;
    } plan_t;

    function automatic logic [FIELD_W-1:0] khz_to_field(input logic [KHZ_W-1:0] khz);
        int v;
        v = (int'(32'(khz)) - 1000) / 500;
        return FIELD_W'(v);
    endfunction

    function automatic logic [KHZ_W-1:0] field_to_khz(input logic [FIELD_W-1:0] field);
        return KHZ_W'(32'(field) * 500 + 1000);
    endfunction

    function automatic logic [31:0] khz_to_units(input logic [KHZ_W-1:0] khz);
        return (32'(khz) + 32'd24999) / 32'd25000;
    endfunction
endpackage

// File: rtl/dclk_decode.sv
`timescale 1ns/1ps
module dclk_decode
    import dclk_pkg::*;
(
    input  logic [KHZ_W-1:0] khz,
    output plan_t            plan
);
    always_comb begin
        plan            = '0;
        plan.field      = khz_to_field(khz);
        plan.final_data = khz_to_units(khz);
        plan.precharge  = (khz >= KHZ_PRECHARGE);
        case (khz)
            20'd144000: begin plan.valid = 1'b1; plan.ratio = RATIO_BASE; plan.div = DIV_4;   end
            20'd288000: begin plan.valid = 1'b1; plan.ratio = RATIO_BASE; plan.div = DIV_2;   end
            20'd384000: begin plan.valid = 1'b1; plan.ratio = RATIO_BASE; plan.div = DIV_1P5; end
            20'd576000: begin plan.valid = 1'b1; plan.ratio = RATIO_BASE; plan.div = DIV_1;   end
            KHZ_TOP:    begin plan.valid = 1'b1; plan.ratio = RATIO_HIGH; plan.div = DIV_1;   end
            KHZ_BYPASS: begin plan.valid = 1'b1; plan.bypass = 1'b1;      plan.div = DIV_1;   end
            default:    plan.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dclk_timeout.sv
`timescale 1ns/1ps
module dclk_timeout #(
    parameter int LIMIT = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/dclk_ctl_image.sv
`timescale 1ns/1ps
module dclk_ctl_image
    import dclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  plan_t            plan,
    output logic [CTL_W-1:0] img,
    output logic [KHZ_W-1:0] img_khz
);
    localparam logic [CTL_W-1:0] RESET_IMG = CTL_W'(khz_to_field(KHZ_BYPASS));
    localparam logic [CTL_W-1:0] KEEP_MASK =
        ~((CTL_W'(2'b11) << DIV_LSB) | (CTL_W'(1'b1) << PRE_BIT) | CTL_W'({FIELD_W{1'b1}}));

    logic [CTL_W-1:0] next_img;

    always_comb begin
        next_img = (img & KEEP_MASK)
                 | (CTL_W'(plan.div) << DIV_LSB)
                 | (CTL_W'(plan.precharge) << PRE_BIT)
                 | CTL_W'(plan.field);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            img <= RESET_IMG;
        end else if (we) begin
            img <= next_img;
        end
    end

    assign img_khz = field_to_khz(img[FIELD_W-1:0]);
endmodule

// File: rtl/dclk_seq.sv
`timescale 1ns/1ps
module dclk_seq
    import dclk_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int LOCK_WAIT_NS  = 200000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [KHZ_W-1:0]   req_khz,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [2:0]         err_code,
    output logic [KHZ_W-1:0]   cur_khz,
    output logic               mbx_req,
    output logic [7:0]         mbx_cmd,
    output logic [31:0]        mbx_data,
    input  logic               mbx_ack,
    input  logic               mbx_fail,
    output logic               pll_en,
    input  logic               pll_lock,
    output logic [RATIO_W-1:0] pll_ratio,
    output logic [CTL_W-1:0]   ctl_img
);
    localparam int WAIT_CYCLES = (LOCK_WAIT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    state_e             st_q;
    plan_t              req_plan;
    plan_t              tgt_q;
    logic [KHZ_W-1:0]   tgt_khz_q;
    logic               need_off_q;
    err_code_e          err_q;
    logic               pll_en_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [KHZ_W-1:0]   cur_q;
    logic [KHZ_W-1:0]   img_khz;
    logic               ctl_we;
    logic               wait_run;
    logic               wait_exp;

    dclk_decode u_dec (
        .khz  (req_khz),
        .plan (req_plan)
    );

    dclk_ctl_image u_img (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl_we),
        .plan    (tgt_q),
        .img     (ctl_img),
        .img_khz (img_khz)
    );

    dclk_timeout #(.LIMIT(WAIT_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (wait_exp)
    );

    assign ctl_we   = (st_q == ST_CTL) && tgt_q.valid;
    assign wait_run = (st_q == ST_PLL_OFF) || (st_q == ST_PLL_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            tgt_q      <= '0;
            tgt_khz_q  <= KHZ_BYPASS;
            need_off_q <= 1'b0;
            err_q      <= ERR_NONE;
            pll_en_q   <= 1'b0;
            ratio_q    <= '0;
            cur_q      <= KHZ_BYPASS;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tgt_q      <= req_plan;
                        tgt_khz_q  <= req_khz;
                        need_off_q <= req_plan.bypass || (req_khz == KHZ_TOP) || (img_khz == KHZ_TOP);
                        if (req_plan.valid) begin
                            err_q <= ERR_NONE;
                            st_q  <= ST_NOTIFY;
                        end else begin
                            err_q <= ERR_BAD_FREQ;
                            st_q  <= ST_FIN;
                        end
                    end
                end
                ST_NOTIFY: begin
                    if (mbx_ack) begin
                        if (mbx_fail) begin
                            err_q <= ERR_NOTIFY;
                            st_q  <= ST_FIN;
                        end else if (need_off_q) begin
                            pll_en_q <= 1'b0;
                            st_q     <= ST_PLL_OFF;
                        end else begin
                            st_q <= ST_RATIO;
                        end
                    end
                end
                ST_PLL_OFF: begin
                    if (!pll_lock) begin
                        st_q <= tgt_q.bypass ? ST_FINAL : ST_RATIO;
                    end else if (wait_exp) begin
                        err_q <= ERR_UNLOCK_TO;
                        st_q  <= ST_FIN;
                    end
                end
                ST_RATIO: begin
                    ratio_q <= tgt_q.ratio;
                    st_q    <= ST_PLL_ON;
                end
                ST_PLL_ON: begin
                    pll_en_q <= 1'b1;
                    if (pll_en_q && pll_lock) begin
                        st_q <= ST_CTL;
                    end else if (wait_exp) begin
                        err_q <= ERR_LOCK_TO;
                        st_q  <= ST_FIN;
                    end
                end
                ST_CTL: begin
                    st_q <= ST_FINAL;
                end
                ST_FINAL: begin
                    if (mbx_ack) begin
                        if (mbx_fail) begin
                            err_q <= ERR_FINAL;
                        end else begin
                            cur_q <= tgt_khz_q;
                        end
                        st_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_FIN);
    assign err       = done && (err_q != ERR_NONE);
    assign err_code  = err_q;
    assign cur_khz   = cur_q;
    assign mbx_req   = (st_q == ST_NOTIFY) || (st_q == ST_FINAL);
    assign mbx_cmd   = MBX_CMD_FREQ;
    assign mbx_data  = (st_q == ST_NOTIFY) ? MBX_NOTIFY_DATA : tgt_q.final_data;
    assign pll_en    = pll_en_q;
    assign pll_ratio = ratio_q;
endmodule

// File: rtl/dclk_seq_chk.sv
`timescale 1ns/1ps
module dclk_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [2:0]  err_code,
    input logic [19:0] cur_khz,
    input logic        mbx_req,
    input logic [7:0]  mbx_cmd,
    input logic        pll_en,
    input logic        pll_lock,
    input logic [7:0]  pll_ratio,
    input logic [31:0] ctl_img
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && busy));

    p_mbx_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        mbx_req |-> (mbx_cmd == 8'h17));

    p_ctl_after_lock_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_img) |-> $past(pll_en && pll_lock));

    p_ratio_before_enable_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> $stable(pll_ratio));

    p_precharge_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctl_img) |-> (ctl_img[16] == (ctl_img[10:0] >= 11'd998)));

    p_cur_on_success_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_khz) |-> (done && !err));

    p_bad_freq_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd1) |-> (!mbx_req && $stable(ctl_img) && $stable(pll_en)));
endmodule

bind dclk_seq dclk_seq_chk u_dclk_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .cur_khz   (cur_khz),
    .mbx_req   (mbx_req),
    .mbx_cmd   (mbx_cmd),
    .pll_en    (pll_en),
    .pll_lock  (pll_lock),
    .pll_ratio (pll_ratio),
    .ctl_img   (ctl_img)
);

// File: tb/dclk_seq_bench.sv
`timescale 1ns/1ps
module dclk_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_khz = '0;
    logic        busy, done, err;
    logic [2:0]  err_code;
    logic [19:0] cur_khz;
    logic        mbx_req;
    logic [7:0]  mbx_cmd;
    logic [31:0] mbx_data;
    logic        mbx_ack = 1'b0;
    logic        mbx_fail = 1'b0;
    logic        pll_en;
    logic        pll_lock = 1'b0;
    logic [7:0]  pll_ratio;
    logic [31:0] ctl_img;

    always #2.5 clk = ~clk;

    dclk_seq #(.CLK_PERIOD_PS(5000), .LOCK_WAIT_NS(1000)) u_dclk_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_khz(req_khz),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .cur_khz(cur_khz),
        .mbx_req(mbx_req), .mbx_cmd(mbx_cmd), .mbx_data(mbx_data),
        .mbx_ack(mbx_ack), .mbx_fail(mbx_fail),
        .pll_en(pll_en), .pll_lock(pll_lock), .pll_ratio(pll_ratio), .ctl_img(ctl_img)
    );

    typedef struct {
        int          code;
        logic [31:0] ctl;
        logic [7:0]  ratio;
        logic [19:0] cur;
        int          mbx_n;
        logic [31:0] fin;
        int          falls;
    } exp_t;

    exp_t sb[$];
    exp_t e_pop;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    logic [31:0] m_ctl = 32'h0000_0024;
    logic [7:0]  m_ratio = 8'd0;
    logic [19:0] m_cur = 20'd19200;

    bit mbx_nf = 0, mbx_ff = 0;
    int pll_mode = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // mailbox responder: ack two cycles after a request
    initial begin
        forever begin
            @(negedge clk);
            if (mbx_req && !mbx_ack) begin
                repeat (2) @(negedge clk);
                mbx_fail = (mbx_data == 32'h8000_0000) ? mbx_nf : mbx_ff;
                mbx_ack  = 1'b1;
                @(negedge clk);
                mbx_ack  = 1'b0;
                mbx_fail = 1'b0;
            end
        end
    end

    // PLL model: lock follows enable after three cycles, or forced
    logic [2:0] pll_dly = '0;
    initial begin
        forever begin
            @(negedge clk);
            pll_dly = {pll_dly[1:0], pll_en};
            pll_lock = (pll_mode == 0) ? pll_dly[2] : (pll_mode == 2);
        end
    end

    // monitor: pops expected items on done
    logic        prev_req = 0, prev_en = 0;
    int          mon_n = 0, mon_falls = 0;
    logic [31:0] mon_d0 = '0, mon_d1 = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (mbx_req && !prev_req) begin
                    if (mon_n == 0) mon_d0 = mbx_data;
                    if (mon_n == 1) mon_d1 = mbx_data;
                    mon_n++;
                end
                if (prev_en && !pll_en) mon_falls++;
                if (done) begin
                    if (sb.size() == 0) begin
                        chk(0, "R10 done without request", 1, 0);
                    end else begin
                        e_pop = sb.pop_front();
                        chk(err_code == 3'(e_pop.code), "R1/R3/R5/R9 err_code", 32'(err_code), 32'(e_pop.code));
                        chk(err == (e_pop.code != 0), "R10 err flag", 32'(err), 32'(e_pop.code != 0));
                        chk(busy, "R10 busy at done", 32'(busy), 1);
                        chk(ctl_img == e_pop.ctl, "R8 ctl_img", ctl_img, e_pop.ctl);
                        chk(pll_ratio == e_pop.ratio, "R2 pll_ratio", 32'(pll_ratio), 32'(e_pop.ratio));
                        chk(cur_khz == e_pop.cur, "R9 cur_khz", 32'(cur_khz), 32'(e_pop.cur));
                        chk(mon_n == e_pop.mbx_n, "R3 mailbox message count", 32'(mon_n), 32'(e_pop.mbx_n));
                        if (mon_n >= 1)
                            chk(mon_d0 == 32'h8000_0000, "R3 notify data", mon_d0, 32'h8000_0000);
                        if (e_pop.mbx_n == 2 && mon_n == 2)
                            chk(mon_d1 == e_pop.fin, "R9 final data", mon_d1, e_pop.fin);
                        chk(mon_falls == e_pop.falls, "R4 PLL disable count", 32'(mon_falls), 32'(e_pop.falls));
                    end
                    mon_n = 0;
                    mon_falls = 0;
                end
            end
            prev_req = mbx_req;
            prev_en  = pll_en;
        end
    end

    function automatic bit ref_dec(input int khz, output logic [7:0] r, output logic [1:0] d);
        r = 8'd0; d = 2'd0;
        case (khz)
            144000: begin r = 8'd60; d = 2'd3; return 1; end
            288000: begin r = 8'd60; d = 2'd2; return 1; end
            384000: begin r = 8'd60; d = 2'd1; return 1; end
            576000: begin r = 8'd60; d = 2'd0; return 1; end
            624000: begin r = 8'd65; d = 2'd0; return 1; end
            19200:  return 1;
            default: return 0;
        endcase
    endfunction

    task automatic do_req(input int khz, input bit nf, input bit ff, input int pm, input bit poke);
        exp_t e;
        logic [7:0] r;
        logic [1:0] d;
        bit ok, byp, off, en_before;
        int cur_img;
        while (busy) @(negedge clk);
        mbx_nf = nf; mbx_ff = ff; pll_mode = pm;
        en_before = pll_en;
        ok  = ref_dec(khz, r, d);
        byp = (khz == 19200);
        cur_img = int'(m_ctl[10:0]) * 500 + 1000;
        off = byp || khz == 624000 || cur_img == 624000;
        e.fin = 32'((khz + 24999) / 25000);
        e.falls = 0;
        if (!ok) begin
            e.code = 1; e.mbx_n = 0;
        end else if (nf) begin
            e.code = 2; e.mbx_n = 1;
        end else if (off && pm == 2) begin
            e.code = 3; e.mbx_n = 1; e.falls = int'(en_before);
        end else if (!byp && pm == 1) begin
            e.code = 4; e.mbx_n = 1; e.falls = int'(off && en_before);
            m_ratio = r;
        end else begin
            e.mbx_n = 2; e.falls = int'(off && en_before);
            if (!byp) begin
                m_ratio = r;
                m_ctl = (m_ctl & ~32'h00C1_07FF) | (32'(d) << 22)
                      | (32'(khz >= 500000) << 16) | 32'((khz - 1000) / 500);
            end
            e.code = ff ? 5 : 0;
            if (!ff) m_cur = 20'(khz);
        end
        e.ctl = m_ctl; e.ratio = m_ratio; e.cur = m_cur;
        sb.push_back(e);
        req_khz = 20'(khz); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy, "R10 busy during sequence", 32'(busy), 1);
            req_khz = 20'd144000; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 3000 && sb.size() != 0; i++) @(negedge clk);
        if (sb.size() != 0) begin
            chk(0, "R10 request never completed", 0, 1);
            sb.delete();
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R11 idle after reset", {busy, done}, 0);
        chk(!pll_en && !mbx_req, "R11 PLL and mailbox quiet", {pll_en, mbx_req}, 0);
        chk(pll_ratio == 8'd0, "R11 ratio reset", 32'(pll_ratio), 0);
        chk(ctl_img == 32'h24, "R11 ctl reset", ctl_img, 32'h24);
        chk(cur_khz == 20'd19200 && err_code == 3'd0, "R11 cur and code reset", 32'(cur_khz), 19200);

        do_req(123456, 0, 0, 0, 0);   // R1 reject
        do_req(288000, 0, 0, 0, 0);   // R2 R8 no toggle
        do_req(576000, 0, 0, 0, 0);   // R7 precharge on
        do_req(624000, 0, 0, 0, 1);   // R4 toggle on target, R10 ignore strobe
        do_req(384000, 0, 0, 0, 0);   // R4 toggle from current 624
        do_req(144000, 1, 0, 0, 0);   // R3 notify failure
        do_req(144000, 0, 1, 0, 0);   // R9 final failure
        do_req(624000, 0, 0, 1, 0);   // R5 lock timeout
        do_req(19200,  0, 0, 2, 0);   // R5 unlock timeout
        do_req(19200,  0, 0, 0, 0);   // R8 bypass keeps ctl
        do_req(144000, 0, 0, 0, 0);   // R6 relock from bypass

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule